// File: doc/BRIEF.md
# PCM Transmit Serial Port

This block sends one 8-bit PCM code word per frame on a serial data pin that can be switched to high impedance. A transmit frame sync marks each time slot, and a bit clock clocks the bits out. A fast system clock samples both inputs through synchronizers, so every timing decision is made in that one clock domain. The encoder presents the code word on a parallel input. The port copies the word at the moment its driver turns on and then sends it sign bit first, one bit per bit-clock rising edge.

The port handles two framing formats. It chooses between them by measuring how many bit-clock falling edges each sync pulse spans. A one-edge pulse selects the short format. A pulse of three or more edges selects the long format. A two-edge pulse changes nothing. The selected format applies to the frames that start after the measuring pulse has ended. In the long format, the driver turns on at the later of the sync rise and a bit-clock rise, and turns off at the later of the sync fall and the bit-clock fall that ends the last bit. An active-low slot indicator mirrors the interval in which the driver is on. The power-control enable gates all of this. After reset or re-enable, the first sync is only counted, so output starts with the second sync.

Top module: `pcm_tx_port`

## Requirements
- R1: While the port is in reset or disabled, `txOe` is 0 and `slotN` is 1. Reset and disable both set the framing format to short.
- R2: When a sync pulse ends, the format becomes short if the pulse covered exactly one bit-clock falling edge. It becomes long if the pulse covered three or more. A frame keeps the format that was in force when the frame started.
- R3: A sync pulse that covers exactly two falling edges leaves the format unchanged, and its frame is still sent in the current format.
- R4: Short format: when the sync is high at a bit-clock falling edge, the next bit-clock rising edge turns the driver on. The driver turns off at the first falling edge after the eighth bit has been presented.
- R5: Long format: if the bit clock is high when the sync rises, the driver turns on at the sync rise. Otherwise it turns on at the next bit-clock rising edge.
- R6: Long format: the driver turns off at the later of two events, the sync going low and the bit-clock falling edge that follows the eighth bit. The last bit is held until then.
- R7: The word is sent most-significant (sign) bit first. It is presented when the driver turns on, and each of the next seven bit-clock rising edges presents the next lower bit.
- R8: The parallel word is captured when the driver turns on. Changes to `txWord` later in the slot do not alter the bits being sent.
- R9: `slotN` is low exactly while `txOe` is high. `txData` reads 0 whenever `txOe` is low.
- R10: After reset or after `portEn` rises, the first sync pulse produces no output, and output begins with the second pulse. Dropping `portEn` during a slot turns the driver off at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bit clock and sync |
| rstN | input | 1 | Active-low asynchronous reset |
| portEn | input | 1 | Enable from power control (system clock domain) |
| bitClk | input | 1 | Serial bit clock, asynchronous to `clk` |
| frameSync | input | 1 | Transmit frame sync, asynchronous to `clk` |
| txWord | input | 8 | Code word from the encoder |
| txData | output | 1 | Serial data; valid while `txOe` is high |
| txOe | output | 1 | Enable for the serial data output driver |
| slotN | output | 1 | Active-low time-slot indicator |

## Verification
The bench runs frames with many code words and sync widths of one, two, three and more edges, including pulses that stay high past the eighth bit. It raises the sync in both halves of the bit clock. This catches a port that turns on one bit period late in the long format, one that cuts the last bit short while the sync is still high, and one that treats a two-edge pulse as long and shifts the next frame's start by a whole bit. The bench changes the encoder word in the middle of each slot, so a port that reads the word live sends mixed bits. It also runs frames after reset, after re-enable and after a mid-slot disable. These expose a port that drives on the first sync, that forgets to return to the short format, or that keeps driving after the enable drops.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;    // capture the parallel word, sign bit first
    logic shift;   // present the next lower bit
    logic drvOn;   // turn the output driver on
    logic drvOff;  // turn the output driver off
  } txStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,   // waiting for an allowed frame start
    ST_ARM,    // frame accepted, waiting for a bit clock rise
    ST_SHIFT,  // driver on, bits being presented
    ST_DRAIN   // last bit presented, waiting for the turn-off event
  } txState_t;

endpackage

// File: rtl/pcm_tx_sync.sv
module pcm_tx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic level,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              lastLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain     <= '0;
      lastLevel <= 1'b0;
    end else begin
      chain[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      lastLevel <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~lastLevel;
  assign fall  = ~chain[STAGES-1] & lastLevel;

endmodule

// File: rtl/pcm_tx_ctrl.sv
module pcm_tx_ctrl
  import pcm_tx_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int LONG_MIN = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      portEn,
  input  logic      bclkLvl,
  input  logic      bclkRise,
  input  logic      bclkFall,
  input  logic      fsLvl,
  input  logic      fsRise,
  input  logic      fsFall,
  output txStrobe_t strobe
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int WID_W = $clog2(LONG_MIN + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W);
  localparam logic [WID_W-1:0] LONG_WID = WID_W'(LONG_MIN);
  localparam bit SINGLE_BIT = (WORD_W == 1);

  txState_t         state, stNext;
  logic [CNT_W-1:0] bitCnt, bitNext;
  logic [WID_W-1:0] widthCnt;
  logic [1:0]       syncCnt, syncAfter;
  logic             modeLong, frameLong, pulseUsed, fallSeen;
  logic             allow, longGo, shortGo, startLong, startShort, endNow;

  // count of syncs seen since enable, including one rising this cycle
  assign syncAfter  = (fsRise && syncCnt != 2'd2) ? syncCnt + 2'd1 : syncCnt;
  assign allow      = portEn && (syncAfter == 2'd2);
  assign longGo     = modeLong && fsRise;
  assign shortGo    = !modeLong && bclkFall && fsLvl && !pulseUsed;
  assign startLong  = (state == ST_IDLE) && allow && longGo;
  assign startShort = (state == ST_IDLE) && allow && shortGo;
  assign endNow     = frameLong ? ((fallSeen || bclkFall) && !fsLvl) : bclkFall;

  always_comb begin
    stNext  = state;
    bitNext = bitCnt;
    strobe  = '0;
    case (state)
      ST_IDLE: begin
        if (startLong) begin
          if (bclkLvl) begin
            strobe.load  = 1'b1;
            strobe.drvOn = 1'b1;
            bitNext      = CNT_W'(1);
            stNext       = SINGLE_BIT ? ST_DRAIN : ST_SHIFT;
          end else begin
            stNext = ST_ARM;
          end
        end else if (startShort) begin
          stNext = ST_ARM;
        end
      end
      ST_ARM: begin
        if (bclkRise) begin
          strobe.load  = 1'b1;
          strobe.drvOn = 1'b1;
          bitNext      = CNT_W'(1);
          stNext       = SINGLE_BIT ? ST_DRAIN : ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (bclkRise) begin
          strobe.shift = 1'b1;
          bitNext      = bitCnt + CNT_W'(1);
          if (bitCnt + CNT_W'(1) == LAST_BIT) stNext = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (endNow) begin
          strobe.drvOff = 1'b1;
          stNext        = ST_IDLE;
        end
      end
      default: stNext = ST_IDLE;
    endcase
    if (!portEn) begin
      strobe        = '0;
      strobe.drvOff = 1'b1;
      stNext        = ST_IDLE;
      bitNext       = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      frameLong <= 1'b0;
      fallSeen  <= 1'b0;
      pulseUsed <= 1'b0;
    end else begin
      state    <= stNext;
      bitCnt   <= bitNext;
      fallSeen <= (state == ST_DRAIN) && (fallSeen || bclkFall);
      if (startLong) frameLong <= 1'b1;
      else if (startShort) frameLong <= 1'b0;
      if (startLong || startShort) pulseUsed <= 1'b1;
      else if (fsRise) pulseUsed <= 1'b0;
    end
  end

  // sync width measurement and format selection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthCnt <= '0;
      modeLong <= 1'b0;
      syncCnt  <= 2'd0;
    end else begin
      if (fsRise) widthCnt <= '0;
      else if (bclkFall && fsLvl && widthCnt != LONG_WID) widthCnt <= widthCnt + WID_W'(1);

      if (!portEn) begin
        modeLong <= 1'b0;
        syncCnt  <= 2'd0;
      end else begin
        syncCnt <= syncAfter;
        if (fsFall) begin
          if (widthCnt == WID_W'(1)) modeLong <= 1'b0;
          else if (widthCnt >= LONG_WID) modeLong <= 1'b1;
        end
      end
    end
  end

  // R7
  bit_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_BIT);

  // R10
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |=> (state == ST_IDLE));

  // R2
  mode_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeLong != $past(modeLong)) |-> ($past(fsFall) || !$past(portEn)));

endmodule

// File: rtl/pcm_tx_dpath.sv
module pcm_tx_dpath
  import pcm_tx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [WORD_W-1:0] wordIn,
  output logic              txData,
  output logic              txOe,
  output logic              slotN
);

  localparam int MSB = WORD_W - 1;

  logic [WORD_W-1:0] shiftReg;
  logic              oeReg, slotReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      oeReg    <= 1'b0;
      slotReg  <= 1'b1;
    end else begin
      if (strobe.load) shiftReg <= wordIn;
      else if (strobe.shift) shiftReg <= {shiftReg[MSB-1:0], 1'b0};
      if (strobe.drvOff) begin
        oeReg   <= 1'b0;
        slotReg <= 1'b1;
      end else if (strobe.drvOn) begin
        oeReg   <= 1'b1;
        slotReg <= 1'b0;
      end
    end
  end

  assign txData = oeReg & shiftReg[MSB];
  assign txOe   = oeReg;
  assign slotN  = slotReg;

  // R8
  sign_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txOe) |-> (txData == $past(wordIn[MSB])));

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txOe && !strobe.shift && !strobe.drvOff) |=> (txData == $past(txData)));

endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port
  import pcm_tx_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LONG_MIN    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              bitClk,
  input  logic              frameSync,
  input  logic [WORD_W-1:0] txWord,
  output logic              txData,
  output logic              txOe,
  output logic              slotN
);

  logic      bclkLvl, bclkRise, bclkFall;
  logic      fsLvl, fsRise, fsFall;
  txStrobe_t strobe;

  pcm_tx_sync #(.STAGES(SYNC_STAGES)) u_bclkSync (
    .clk(clk), .rstN(rstN), .asyncIn(bitClk),
    .level(bclkLvl), .rise(bclkRise), .fall(bclkFall)
  );

  pcm_tx_sync #(.STAGES(SYNC_STAGES)) u_fsSync (
    .clk(clk), .rstN(rstN), .asyncIn(frameSync),
    .level(fsLvl), .rise(fsRise), .fall(fsFall)
  );

  pcm_tx_ctrl #(.WORD_W(WORD_W), .LONG_MIN(LONG_MIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .portEn(portEn),
    .bclkLvl(bclkLvl), .bclkRise(bclkRise), .bclkFall(bclkFall),
    .fsLvl(fsLvl), .fsRise(fsRise), .fsFall(fsFall),
    .strobe(strobe)
  );

  pcm_tx_dpath #(.WORD_W(WORD_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIn(txWord),
    .txData(txData), .txOe(txOe), .slotN(slotN)
  );

endmodule

// File: tb/pcm_tx_port_tb.sv
module pcm_tx_port_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       portEn = 1'b0;
  logic       bitClk = 1'b0;
  logic       frameSync = 1'b0;
  logic [7:0] txWord = 8'h00;
  logic       txData, txOe, slotN;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pcm_tx_port u_dut (
    .clk(clk), .rstN(rstN), .portEn(portEn), .bitClk(bitClk),
    .frameSync(frameSync), .txWord(txWord),
    .txData(txData), .txOe(txOe), .slotN(slotN)
  );

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic sampleAll(input string req, input bit expOn, input bit expBit);
    chk(req, "txOe", int'(txOe), int'(expOn));
    chk(req, "slotN R9", int'(slotN), int'(!expOn));
    chk(req, "txData R7 R8", int'(txData), expOn ? int'(expBit) : 0);
  endtask

  // One frame: sync raised in period 0 (high half if early, else low half),
  // lowered in the high half of period lowerAt. Each half lasts 10 clocks,
  // changes land 1 clock into a half, samples 7 clocks into it.
  task automatic runFrame(input string req, input logic [7:0] word, input int lowerAt,
                          input bit early, input bit isLong, input bit expTx, input int abortAt);
    int s;
    int last;
    s    = early ? 0 : 1;
    last = ((lowerAt > 10) ? lowerAt : 10) + 1;
    txWord = word;
    for (int k = 0; k <= last; k++) begin
      for (int h = 0; h < 2; h++) begin
        bit hi;
        bit on;
        int idx;
        int hiLast;
        int loLast;
        hi = (h == 0);
        bitClk = hi;
        waitN(1);
        if (k == 0 && (early == hi)) frameSync = 1'b1;
        if (k == lowerAt && hi) frameSync = 1'b0;
        if (k == abortAt && hi) portEn = 1'b0;
        if (k == 4 && hi) txWord = ~word;
        waitN(6);
        on  = 1'b0;
        idx = 0;
        if (expTx && !(abortAt >= 0 && k >= abortAt)) begin
          if (isLong) begin
            hiLast = (s + 7 > lowerAt - 1) ? s + 7 : lowerAt - 1;
            loLast = (s + 6 > lowerAt - 1) ? s + 6 : lowerAt - 1;
            on  = (k >= s) && (k <= (hi ? hiLast : loLast));
            idx = 7 - (k - s);
          end else begin
            on  = (k >= 2) && (k <= (hi ? 9 : 8));
            idx = 9 - k;
          end
          if (idx < 0) idx = 0;
          if (idx > 7) idx = 7;
        end
        sampleAll(req, on, word[idx]);
        waitN(3);
      end
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    waitN(150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog R1 actual=running expected=done");
      finishRun();
    end
  end

  initial begin
    int lows[6] = '{4, 5, 8, 9, 10, 12};
    waitN(4);
    sampleAll("R1", 1'b0, 1'b0);          // R1 in reset
    rstN = 1'b1;
    waitN(5);
    sampleAll("R1", 1'b0, 1'b0);          // R1 after reset
    runFrame("R1", 8'hA5, 2, 1'b0, 1'b0, 1'b0, -1);  // R1 disabled: no output
    portEn = 1'b1;
    waitN(3);
    runFrame("R10", 8'h3C, 2, 1'b0, 1'b0, 1'b0, -1); // R10 first sync only counted
    runFrame("R4", 8'h80, 2, 1'b0, 1'b0, 1'b1, -1);
    runFrame("R4", 8'h01, 2, 1'b0, 1'b0, 1'b1, -1);
    for (int i = 0; i < 8; i++)
      runFrame("R4", 8'((i * 41) ^ 150), 2, 1'b0, 1'b0, 1'b1, -1);
    // R2 long pulse in short format: sent short, then format becomes long
    runFrame("R2", 8'h5A, 5, 1'b0, 1'b0, 1'b1, -1);
    for (int i = 0; i < 6; i++)
      runFrame("R6", 8'((i * 77) ^ 53), lows[i], 1'b0, 1'b1, 1'b1, -1);
    runFrame("R5", 8'hC3, 4, 1'b1, 1'b1, 1'b1, -1);  // R5 sync rises with bit clock high
    runFrame("R5", 8'h96, 9, 1'b1, 1'b1, 1'b1, -1);
    runFrame("R3", 8'h6E, 3, 1'b0, 1'b1, 1'b1, -1);  // R3 two-edge pulse keeps long
    runFrame("R3", 8'h17, 3, 1'b0, 1'b1, 1'b1, -1);
    portEn = 1'b0;
    waitN(40);
    sampleAll("R1", 1'b0, 1'b0);
    portEn = 1'b1;
    waitN(3);
    runFrame("R10", 8'hE1, 3, 1'b0, 1'b0, 1'b0, -1); // R10 first sync after re-enable
    runFrame("R1", 8'h4B, 3, 1'b0, 1'b0, 1'b1, -1);  // R1 format back to short
    runFrame("R3", 8'hD2, 3, 1'b0, 1'b0, 1'b1, -1);  // R3 two-edge pulse keeps short
    runFrame("R10", 8'hFF, 2, 1'b0, 1'b0, 1'b1, 4);  // R10 disable mid-slot
    portEn = 1'b1;
    waitN(3);
    runFrame("R10", 8'h33, 2, 1'b0, 1'b0, 1'b0, -1);
    runFrame("R4", 8'h00, 2, 1'b0, 1'b0, 1'b1, -1);
    runFrame("R4", 8'h7F, 2, 1'b0, 1'b0, 1'b1, -1);
    finishRun();
  end

endmodule